// File: doc/BRIEF.md
# Smart-Card Clock and Elementary Time Unit Generator

This block turns the peripheral clock into the clock pin for a contact smart card and derives the serial bit-rate tick from that clock. A half-period counter loaded from an 8-bit divisor runs a free-running virtual card clock. The visible card clock pin follows the virtual clock's half-period boundaries. When a stop is requested, the pin is parked at a selectable level. The virtual clock keeps running the whole time.

The bit-rate tick comes from two counters. The first counts virtual card-clock rising edges modulo a programmable constant. The second counts that prescaler's outputs in groups of 31 or 32. Each completed group produces a pulse one peripheral clock wide. The surrounding protocol logic holds the enable high while the card's reset line is released. A one-cycle re-initialise strobe is issued on power-good or on an activation write. It restarts the whole chain so that the start-up timing does not depend on where the divider happened to be.

Top module: `sc_clk_etu_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `card_clk` goes low, `etu_tick` goes low and all internal counters clear.
- R2: With no stop pending, `card_clk` holds each level for max(`half_div`,1) peripheral cycles. A divisor of 0 therefore toggles the pin every cycle.
- R3: `card_clk` changes only at a half-period boundary. A new `half_div` value applies only from the next boundary, so the half-period in progress completes at its old length and no runt pulse appears.
- R4: While `stop_req` is 1, the first boundary at which `card_clk` equals `stop_high` parks the pin at that level (0 = low, 1 = high) for as long as the request stays.
- R5: After `stop_req` returns to 0, the pin toggles at a boundary, and the half-period that follows has the full length.
- R6: The prescaler counts virtual card-clock rising edges modulo max(`etu_div`,1). A value of 0 behaves as 1.
- R7: One ETU spans 31 prescaler outputs when `etu_wide` is 0 and 32 when it is 1. With `half_div`=1 and `etu_div`=1, the ticks are 62 or 64 peripheral cycles apart. With `etu_div`=3 and `etu_wide`=0, they are 186 apart.
- R8: `etu_tick` is high for exactly one peripheral cycle at a time, and it keeps occurring while `card_clk` is parked.
- R9: While `run_en` is 0, `etu_tick` stays low and both ETU counters clear.
- R10: A cycle with `reinit` high drives `card_clk` low, clears the ETU counters and loads the half-period counter. The pin then rises exactly max(`half_div`,1) cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, all logic on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | ETU generation enable (held while card reset is released) |
| reinit | input | 1 | One-cycle divider re-initialise strobe |
| half_div | input | DIV_W | Card-clock half period in peripheral cycles, 0 acts as 1 |
| etu_div | input | DIV_W | ETU prescaler modulus in card-clock cycles, 0 acts as 1 |
| etu_wide | input | 1 | ETU length select: 0 = 31, 1 = 32 prescaler outputs |
| stop_req | input | 1 | Request to park the card clock |
| stop_high | input | 1 | Park level: 0 = low, 1 = high |
| card_clk | output | 1 | Card clock pin |
| etu_tick | output | 1 | One-cycle elementary time unit pulse |

## Verification
The bench builds the block with the default `DIV_W` of 8. It keeps the divisors between 0 and 6, so that a full 31- or 32-unit ETU lasts between 62 and a few hundred peripheral cycles. With these values, tick spacing, divisor changes in the middle of a period, parking at both levels with ticks still running, restart, enable gating and re-initialisation all fall inside a few thousand cycles. Each is compared cycle by cycle against a behavioural model.

// File: rtl/sc_clk_pkg.sv
// Package: shared constants and types for the smart-card clock / ETU generator.
// Assumes: ETU unit counts are fixed by the card standard (31 or 32).
package sc_clk_pkg;

    localparam int unsigned ETU_UNITS_SHORT = 31;
    localparam int unsigned ETU_UNITS_LONG  = 32;
    localparam int unsigned ETU_UNIT_W      = $clog2(ETU_UNITS_LONG);

    typedef struct packed {
        logic req;    // park the card clock
        logic level;  // level to park at
    } stop_ctrl_t;

endpackage

// File: rtl/sc_half_period_gen.sv
// Module: half-period counter producing the free-running virtual card clock.
// What it does: counts max(half_div,1) peripheral cycles per half period and
//   flags each boundary; the divisor is sampled only when a new half period
//   is loaded.
// Assumes: reinit has priority over normal counting.
module sc_half_period_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reinit,
    input  logic [DIV_W-1:0] half_div,
    output logic             boundary,
    output logic             vclk_rise
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] hcnt;
    logic             vclk_q;
    logic [DIV_W-1:0] n_eff;
    logic [DIV_W-1:0] load_val;

    // Effective half period and its reload value.
    always_comb begin
        n_eff    = (half_div == '0) ? ONE : half_div;
        load_val = n_eff - ONE;
    end

    assign boundary  = (hcnt == '0);
    assign vclk_rise = boundary && !vclk_q;

    // Down-count one half period, reload and toggle the virtual clock at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt   <= '0;
            vclk_q <= 1'b0;
        end else if (reinit) begin
            hcnt   <= load_val;
            vclk_q <= 1'b0;
        end else if (boundary) begin
            hcnt   <= load_val;
            vclk_q <= ~vclk_q;
        end else begin
            hcnt   <= hcnt - ONE;
        end
    end

endmodule

// File: rtl/sc_pin_gate.sv
// Module: card clock pin driver with stop-at-level control.
// What it does: toggles the pin at each half-period boundary unless a stop
//   is pending and the pin already sits at the requested park level.
// Assumes: boundary comes from sc_half_period_gen; reinit parks the pin low.
module sc_pin_gate
    import sc_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reinit,
    input  logic       boundary,
    input  stop_ctrl_t stop,
    output logic       card_clk
);
    logic pin_q;
    logic hold;

    // Parked when a stop is requested and the pin is already at the level.
    assign hold     = stop.req && (pin_q == stop.level);
    assign card_clk = pin_q;

    // Registered pin: toggles only on boundaries, never mid half-period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (reinit) begin
            pin_q <= 1'b0;
        end else if (boundary && !hold) begin
            pin_q <= ~pin_q;
        end
    end

endmodule

// File: rtl/sc_etu_counter.sv
// Module: ETU prescaler plus unit counter producing the bit-rate tick.
// What it does: counts virtual card-clock rises modulo max(etu_div,1), then
//   counts those outputs in groups of 31 or 32 and pulses tick once per group.
// Assumes: vclk_rise is never high on two consecutive cycles.
module sc_etu_counter
    import sc_clk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reinit,
    input  logic             run_en,
    input  logic             vclk_rise,
    input  logic [DIV_W-1:0] etu_div,
    input  logic             etu_wide,
    output logic             tick
);
    localparam int UNIT_W = ETU_UNIT_W;
    localparam logic [DIV_W-1:0]  P_ONE      = DIV_W'(1);
    localparam logic [UNIT_W-1:0] U_ONE      = UNIT_W'(1);
    localparam logic [UNIT_W-1:0] U_LAST_S   = UNIT_W'(ETU_UNITS_SHORT - 1);
    localparam logic [UNIT_W-1:0] U_LAST_L   = UNIT_W'(ETU_UNITS_LONG - 1);

    logic [DIV_W-1:0]  pcnt;
    logic [UNIT_W-1:0] ucnt;
    logic [DIV_W-1:0]  p_last;
    logic [UNIT_W-1:0] u_last;
    logic              p_wrap;
    logic              u_wrap;
    logic              tick_q;

    // Terminal counts; >= tolerates a modulus lowered mid-count.
    always_comb begin
        p_last = ((etu_div == '0) ? P_ONE : etu_div) - P_ONE;
        u_last = etu_wide ? U_LAST_L : U_LAST_S;
        p_wrap = (pcnt >= p_last);
        u_wrap = (ucnt >= u_last);
    end

    assign tick = tick_q;

    // Advance prescaler and unit counter on each virtual clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n || reinit || !run_en) begin
            pcnt   <= '0;
            ucnt   <= '0;
            tick_q <= 1'b0;
        end else if (vclk_rise) begin
            tick_q <= p_wrap && u_wrap;
            if (p_wrap) begin
                pcnt <= '0;
                ucnt <= u_wrap ? '0 : (ucnt + U_ONE);
            end else begin
                pcnt <= pcnt + P_ONE;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sc_clk_etu_gen.sv
// Module: top of the smart-card clock and ETU generator.
// What it does: ties the half-period generator, the pin gate and the ETU
//   counter together; the ETU runs from the virtual clock so it continues
//   while the visible pin is parked.
// Assumes: all inputs are synchronous to clk.
module sc_clk_etu_gen
    import sc_clk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             reinit,
    input  logic [DIV_W-1:0] half_div,
    input  logic [DIV_W-1:0] etu_div,
    input  logic             etu_wide,
    input  logic             stop_req,
    input  logic             stop_high,
    output logic             card_clk,
    output logic             etu_tick
);
    logic       half_bnd;
    logic       half_rise;
    stop_ctrl_t stop_c;

    // Bundle the stop controls for the pin gate.
    always_comb begin
        stop_c.req   = stop_req;
        stop_c.level = stop_high;
    end

    sc_half_period_gen #(.DIV_W(DIV_W)) u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .reinit    (reinit),
        .half_div  (half_div),
        .boundary  (half_bnd),
        .vclk_rise (half_rise)
    );

    sc_pin_gate u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .reinit   (reinit),
        .boundary (half_bnd),
        .stop     (stop_c),
        .card_clk (card_clk)
    );

    sc_etu_counter #(.DIV_W(DIV_W)) u_etu (
        .clk       (clk),
        .rst_n     (rst_n),
        .reinit    (reinit),
        .run_en    (run_en),
        .vclk_rise (half_rise),
        .etu_div   (etu_div),
        .etu_wide  (etu_wide),
        .tick      (etu_tick)
    );

endmodule

// File: rtl/sc_clk_etu_chk.sv
// Module: property checker bound to sc_clk_etu_gen.
// What it does: checks pin edge placement, parking, tick width and gating.
// Assumes: boundary and vclk_rise are the top's internal half-period signals.
module sc_clk_etu_chk (
    input logic clk,
    input logic rst_n,
    input logic reinit,
    input logic run_en,
    input logic stop_req,
    input logic stop_high,
    input logic card_clk,
    input logic etu_tick,
    input logic boundary,
    input logic vclk_rise
);
    // R3: the pin only moves after a boundary or a re-initialise.
    assert_edge_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(card_clk) |-> $past(boundary || reinit));

    // R4: a parked pin stays put across the boundary.
    assert_park_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !reinit && stop_req && (card_clk == stop_high)) |=> $stable(card_clk));

    // R8: tick is one cycle wide.
    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        etu_tick |=> !etu_tick);

    // R6: a tick follows a virtual clock rise while enabled.
    assert_tick_from_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        etu_tick |-> $past(vclk_rise && run_en && !reinit));

    // R9: disabled generator emits no tick.
    assert_idle_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !etu_tick);

    // R10: re-initialise drives the pin low.
    assert_reinit_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !card_clk);

endmodule

bind sc_clk_etu_gen sc_clk_etu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reinit    (reinit),
    .run_en    (run_en),
    .stop_req  (stop_req),
    .stop_high (stop_high),
    .card_clk  (card_clk),
    .etu_tick  (etu_tick),
    .boundary  (half_bnd),
    .vclk_rise (half_rise)
);

// File: tb/tb_sc_clk_etu_gen.sv
`timescale 1ns/1ps
module tb_sc_clk_etu_gen;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic reinit = 1'b0;
    logic [DIV_W-1:0] half_div = '0;
    logic [DIV_W-1:0] etu_div = 8'd1;
    logic etu_wide = 1'b0;
    logic stop_req = 1'b0;
    logic stop_high = 1'b0;
    logic card_clk, etu_tick;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    sc_clk_etu_gen #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .reinit(reinit),
        .half_div(half_div), .etu_div(etu_div), .etu_wide(etu_wide),
        .stop_req(stop_req), .stop_high(stop_high),
        .card_clk(card_clk), .etu_tick(etu_tick)
    );

    // Behavioural reference model, stepped on every rising edge.
    int m_h, m_pc, m_uc;
    bit m_v, m_c, m_t;
    always @(posedge clk) begin
        int n, e, w;
        bit b, rise;
        n = (half_div == 0) ? 1 : int'(half_div);
        e = (etu_div == 0) ? 1 : int'(etu_div);
        w = etu_wide ? 32 : 31;
        if (!rst_n) begin
            m_h = 0; m_v = 0; m_c = 0; m_pc = 0; m_uc = 0; m_t = 0;
        end else if (reinit) begin
            m_h = n - 1; m_v = 0; m_c = 0; m_pc = 0; m_uc = 0; m_t = 0;
        end else begin
            b = (m_h == 0);
            rise = b && !m_v;
            if (b) begin
                m_h = n - 1;
                m_v = !m_v;
                if (!(stop_req && (m_c == stop_high))) m_c = !m_c;
            end else begin
                m_h = m_h - 1;
            end
            if (!run_en) begin
                m_pc = 0; m_uc = 0; m_t = 0;
            end else if (rise) begin
                m_t = (m_pc >= e - 1) && (m_uc >= w - 1);
                if (m_pc >= e - 1) begin
                    m_pc = 0;
                    m_uc = (m_uc >= w - 1) ? 0 : m_uc + 1;
                end else begin
                    m_pc = m_pc + 1;
                end
            end else begin
                m_t = 0;
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        cyc_cnt++;
        if (rst_n) begin
            n_cmp++;
            if (card_clk !== m_c || etu_tick !== m_t) begin
                n_bad++;
                $display("FAIL %s cycle %0d: card_clk=%0b etu_tick=%0b expected %0b %0b",
                         phase, cyc_cnt, card_clk, etu_tick, m_c, m_t);
            end
        end
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count card_clk toggles over k cycles.
    task automatic count_toggles(input int k, output int t);
        bit prev;
        prev = card_clk;
        t = 0;
        for (int i = 0; i < k; i++) begin
            cyc(1);
            if (card_clk != prev) t++;
            prev = card_clk;
        end
    endtask

    task automatic count_ticks(input int k, output int t);
        t = 0;
        for (int i = 0; i < k; i++) begin
            cyc(1);
            if (etu_tick) t++;
        end
    endtask

    // Cycles until the next tick (bounded).
    task automatic to_tick(output int d);
        d = 0;
        do begin
            cyc(1);
            d++;
        end while (!etu_tick && d < 5000);
    endtask

    // Spacing between ticks once settled.
    task automatic tick_gap(output int d);
        int s;
        to_tick(s);
        to_tick(s);
        to_tick(d);
    endtask

    // Length of the current run of card_clk level (bounded).
    task automatic run_len(output int d);
        bit lv;
        lv = card_clk;
        d = 0;
        do begin
            cyc(1);
            d++;
        end while (card_clk == lv && d < 5000);
    endtask

    initial begin
        int t, d;
        cyc(4);
        phase = "R1";
        check(card_clk, 0, "R1");
        check(etu_tick, 0, "R1");
        rst_n = 1'b1;
        half_div = 8'd3;
        run_en = 1'b1;
        cyc(10);

        phase = "R2";
        count_toggles(60, t);
        check(t, 20, "R2 half_div=3");
        half_div = 8'd0;
        cyc(10);
        count_toggles(30, t);
        check(t, 30, "R2 half_div=0");

        phase = "R3";
        half_div = 8'd6;
        count_toggles(60, t);
        check(t, 10, "R3 divisor change at boundary");

        phase = "R7";
        half_div = 8'd1;
        etu_div = 8'd1;
        etu_wide = 1'b0;
        tick_gap(d);
        check(d, 62, "R7 width 31");
        etu_wide = 1'b1;
        tick_gap(d);
        check(d, 64, "R7 width 32");
        phase = "R6";
        etu_wide = 1'b0;
        etu_div = 8'd0;
        tick_gap(d);
        check(d, 62, "R6 etu_div=0 acts as 1");
        etu_div = 8'd3;
        tick_gap(d);
        check(d, 186, "R6 etu_div=3");
        etu_div = 8'd1;

        phase = "R4";
        half_div = 8'd2;
        stop_high = 1'b1;
        stop_req = 1'b1;
        cyc(20);
        check(card_clk, 1, "R4 parked high");
        phase = "R8";
        count_toggles(200, t);
        check(t, 0, "R4 no toggles while parked");
        count_ticks(260, t);
        check(t >= 2, 1, "R8 ticks continue while parked");
        phase = "R4";
        stop_high = 1'b0;
        cyc(20);
        check(card_clk, 0, "R4 parked low");
        count_toggles(50, t);
        check(t, 0, "R4 stays low");

        phase = "R5";
        stop_req = 1'b0;
        run_len(d);
        check(d <= 2, 1, "R5 restart at a boundary");
        run_len(d);
        check(d, 2, "R5 first half period full");

        phase = "R9";
        run_en = 1'b0;
        count_ticks(300, t);
        check(t, 0, "R9 no ticks when disabled");
        run_en = 1'b1;
        cyc(300);

        phase = "R10";
        half_div = 8'd4;
        cyc(7);
        reinit = 1'b1;
        cyc(1);
        reinit = 1'b0;
        check(card_clk, 0, "R10 pin low after reinit");
        run_len(d);
        check(d, 4, "R10 rise after one half period");
        cyc(400);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule